// File: doc/BRIEF.md
# Two-Master Register Port Arbiter

This block shares one 16-bit register port between two masters. The fabric master uses a single-cycle enable with a write flag, an address and write data, and gets a one-cycle ready pulse with read data. The scan-side master sends a one-cycle request with a 4-bit command, an address and data. The register file behind the port is a memory inside the block. Every access to it takes `LAT` clock cycles.

Arbitration works one transaction at a time, where a transaction is one read or one write. Once either master has started a transaction, the other master cannot break in. A request that arrives during that time is queued and runs as soon as the port is free. Three flags report the scan side's activity. Busy marks a scan transaction in flight. Modified marks that the scan side has written. Locked marks that fabric access is blocked. Scan-side writes to addresses 0, 2 and 3 have side effects:

- Address 0 sets or clears the fabric lockout.
- Address 2 enables the auxiliary inputs.
- Address 3 produces a reset pulse.

None of these three writes is stored in the memory.

Top module: `regport_arbiter`

## Requirements
- R1: When the port is idle and unlocked, a fabric enable sampled at edge n gives a ready pulse that is high for exactly one cycle, after edge n+LAT+1. A write stores `f_din` at `f_addr`. A read returns the stored word on `f_dout`.
- R2: A fabric enable that arrives while an earlier fabric request is still pending or in progress is ignored. It produces no extra ready pulse and has no effect on memory.
- R3: A scan request that arrives while a fabric transaction is in progress does not disturb it. The fabric ready pulse comes at its normal time, and the scan access runs afterwards and sees the fabric write.
- R4: A fabric request that arrives during a scan transaction is queued. Its ready pulse comes only after busy has fallen, and a fabric read then returns the word just written by the scan side.
- R5: A valid scan request is accepted only while busy is low. Busy is high from the edge that accepts the request until the edge that completes the transaction:
  - that is LAT+1 edges when the port is idle;
  - it is never more than 2*LAT+1 edges in any case, which is within ten cycles for LAT up to 4.
- R6: Modified goes high when a scan write completes. It goes low when the next fabric transaction completes.
- R7: A scan write to address 0 changes the lockout as follows:
  - data 0x0001 sets it and data 0x0000 clears it;
  - any other value leaves it unchanged.
  While it is set, `locked` is high and fabric requests wait without a ready pulse. They complete after the lockout is cleared.
- R8: A scan write of any value to address 3 drives `sys_rst` high for exactly one cycle, in the same cycle that busy falls. The stored word at address 3 is not changed.
- R9: A scan write of 0x0001 to address 2 sets `aux_en`, which then stays high until reset. Other values do not set it. Scan writes never change the stored word at address 2.
- R10: `j_dout` loads the stored word when a scan read (command 1) completes. It holds its value at all other times, including across scan writes (command 2).
- R11: In reset, `busy`, `f_rdy`, `modified`, `aux_en` and `sys_rst` are low and `locked` is high. After reset is released, `locked` stays high for exactly WARM clock edges.
- R12: A scan request whose command is neither 1 (read) nor 2 (write) is ignored. This includes 0, which means no operation. Busy does not rise, and memory, `j_dout` and `modified` are unchanged.
- R13: When a fabric request and a scan request reach an idle port in the same cycle, the scan transaction runs first. Busy falls after LAT+1 edges and the fabric ready pulse follows after 2*LAT+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_en | input | 1 | Fabric request strobe |
| f_we | input | 1 | Fabric write when high, read when low |
| f_addr | input | AW | Fabric address |
| f_din | input | DW | Fabric write data |
| f_dout | output | DW | Fabric read data, valid with `f_rdy` |
| f_rdy | output | 1 | Fabric transaction done, one-cycle pulse |
| j_req | input | 1 | Scan-side request strobe |
| j_cmd | input | 4 | Scan command: 1 read, 2 write, others ignored |
| j_addr | input | AW | Scan-side address |
| j_din | input | DW | Scan-side write data |
| j_dout | output | DW | Latched result of the last scan read |
| busy | output | 1 | Scan transaction pending or in progress |
| modified | output | 1 | Scan side has written since the last fabric transaction |
| locked | output | 1 | Fabric access blocked (warm-up or lockout) |
| aux_en | output | 1 | Auxiliary-input enable |
| sys_rst | output | 1 | One-cycle reset pulse requested by the scan side |

## Verification
The assertions assume that each master waits for its own previous transaction to finish before it issues the next one. The scan side waits for busy to fall, and the fabric side waits for its ready pulse. Under that assumption the bounds on busy length and the one-cycle pulses hold. The stimulus follows this rule: every scenario window lasts long enough for both transactions to finish before the next window starts. Overlap is created only inside a window, by offsetting the two requests by zero or one cycle. The R2 case is the one deliberate exception: it repeats a fabric enable during an outstanding request to confirm the repeat is dropped.

// File: rtl/regport_arbiter.sv
module regport_arbiter #(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter int LAT  = 3,
  parameter int WARM = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_en,
  input  logic          f_we,
  input  logic [AW-1:0] f_addr,
  input  logic [DW-1:0] f_din,
  output logic [DW-1:0] f_dout,
  output logic          f_rdy,
  input  logic          j_req,
  input  logic [3:0]    j_cmd,
  input  logic [AW-1:0] j_addr,
  input  logic [DW-1:0] j_din,
  output logic [DW-1:0] j_dout,
  output logic          busy,
  output logic          modified,
  output logic          locked,
  output logic          aux_en,
  output logic          sys_rst
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);
  localparam int WCW   = $clog2(WARM + 1);
  localparam int BCW   = $clog2(2 * LAT + 2) + 1;
  localparam logic [3:0]    CMD_RD    = 4'h1;
  localparam logic [3:0]    CMD_WR    = 4'h2;
  localparam logic [AW-1:0] ADDR_LOCK = AW'(0);
  localparam logic [AW-1:0] ADDR_AUX  = AW'(2);
  localparam logic [AW-1:0] ADDR_RST  = AW'(3);

  logic [DW-1:0]  mem [DEPTH];
  logic           f_pend, f_we_q, j_pend, j_we_q;
  logic [AW-1:0]  f_addr_q, j_addr_q, a_addr;
  logic [DW-1:0]  f_din_q, j_din_q, a_din;
  logic           act, own_j, a_we, lock_q;
  logic [CW-1:0]  cnt;
  logic [WCW-1:0] warm;
  logic [BCW-1:0] bcnt;

  wire warm_busy = warm != WARM[WCW-1:0];
  assign locked  = lock_q | warm_busy;

  wire f_take  = f_en & ~f_pend & ~(act & ~own_j);
  wire j_take  = j_req & ~busy & (j_cmd == CMD_RD || j_cmd == CMD_WR);
  wire start_j = ~act & j_pend;
  wire start_f = ~act & ~j_pend & f_pend & ~locked;
  wire done    = act && cnt == CW'(LAT - 1);
  wire j_done  = done & own_j;
  wire f_done  = done & ~own_j;
  wire special = a_addr == ADDR_LOCK || a_addr == ADDR_AUX || a_addr == ADDR_RST;
  wire [DW-1:0] rd = mem[a_addr];

  always_ff @(posedge clk)
    if (done && a_we && !(own_j && special)) mem[a_addr] <= a_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_pend <= 1'b0; f_we_q <= 1'b0; f_addr_q <= '0; f_din_q <= '0;
      j_pend <= 1'b0; j_we_q <= 1'b0; j_addr_q <= '0; j_din_q <= '0;
      act <= 1'b0; own_j <= 1'b0; a_we <= 1'b0; a_addr <= '0; a_din <= '0;
      cnt <= '0; warm <= '0; lock_q <= 1'b0;
      f_dout <= '0; f_rdy <= 1'b0; j_dout <= '0; busy <= 1'b0;
      modified <= 1'b0; aux_en <= 1'b0; sys_rst <= 1'b0;
    end else begin
      f_rdy   <= f_done;
      sys_rst <= j_done && a_we && a_addr == ADDR_RST;
      if (warm_busy) warm <= warm + 1'b1;

      if (f_take) begin
        f_pend <= 1'b1; f_we_q <= f_we; f_addr_q <= f_addr; f_din_q <= f_din;
      end else if (start_f) f_pend <= 1'b0;

      if (j_take) begin
        j_pend <= 1'b1; busy <= 1'b1;
        j_we_q <= j_cmd == CMD_WR; j_addr_q <= j_addr; j_din_q <= j_din;
      end else if (start_j) j_pend <= 1'b0;

      if (start_j || start_f) begin
        act    <= 1'b1;
        cnt    <= '0;
        own_j  <= start_j;
        a_we   <= start_j ? j_we_q   : f_we_q;
        a_addr <= start_j ? j_addr_q : f_addr_q;
        a_din  <= start_j ? j_din_q  : f_din_q;
      end else if (done) act <= 1'b0;
      else if (act) cnt <= cnt + 1'b1;

      if (f_done) begin
        modified <= 1'b0;
        if (!a_we) f_dout <= rd;
      end

      if (j_done) begin
        busy <= 1'b0;
        if (a_we) begin
          modified <= 1'b1;
          if (a_addr == ADDR_LOCK && a_din == DW'(1)) lock_q <= 1'b1;
          if (a_addr == ADDR_LOCK && a_din == DW'(0)) lock_q <= 1'b0;
          if (a_addr == ADDR_AUX  && a_din == DW'(1)) aux_en <= 1'b1;
        end else j_dout <= rd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else bcnt <= busy ? bcnt + 1'b1 : '0;

  assert_rdy_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    f_rdy |=> !f_rdy);
  assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt <= BCW'(2 * LAT));
  assert_mod_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modified) |-> $fell(busy));
  assert_mod_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modified) |-> f_rdy);
  assert_locked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !f_rdy);
  assert_rst_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $fell(busy));
  assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);
  assert_jdout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (j_dout != $past(j_dout)) |-> $fell(busy));
  assert_busy_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(j_req));
endmodule

// File: tb/sim_regport_arbiter.sv
module sim_regport_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, DW = 16, LAT = 3, WARM = 10;
  localparam int WIN = 4 * LAT + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_en = 1'b0, f_we = 1'b0, j_req = 1'b0;
  logic [AW-1:0] f_addr = '0, j_addr = '0;
  logic [DW-1:0] f_din = '0, j_din = '0, f_dout, j_dout;
  logic [3:0] j_cmd = '0;
  logic f_rdy, busy, modified, locked, aux_en, sys_rst;

  regport_arbiter #(.AW(AW), .DW(DW), .LAT(LAT), .WARM(WARM)) u0 (
    .clk(clk), .rst_n(rst_n), .f_en(f_en), .f_we(f_we), .f_addr(f_addr), .f_din(f_din),
    .f_dout(f_dout), .f_rdy(f_rdy), .j_req(j_req), .j_cmd(j_cmd), .j_addr(j_addr),
    .j_din(j_din), .j_dout(j_dout), .busy(busy), .modified(modified), .locked(locked),
    .aux_en(aux_en), .sys_rst(sys_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] shadow [64];
  logic [15:0] ejd = '0;
  logic emod = 1'b0;
  int fk, jk, rk, nrdy, nrst;
  logic [15:0] fd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fin_at(input int at, input bit queued);
    return queued ? 2 * LAT + 2 : at + LAT + 1;
  endfunction

  task automatic run(input bit df, input bit fw, input int fa, input logic [15:0] fdv, input int f_at,
                     input bit dj, input logic [3:0] jc, input int ja, input logic [15:0] jdv, input int j_at);
    logic pb;
    fk = -1; jk = -1; rk = -1; nrdy = 0; nrst = 0; fd = '0; pb = busy;
    for (int cyc = 0; cyc < WIN; cyc++) begin
      f_en = df && cyc == f_at; f_we = fw; f_addr = AW'(fa); f_din = fdv;
      j_req = dj && cyc == j_at; j_cmd = jc; j_addr = AW'(ja); j_din = jdv;
      @(posedge clk); @(negedge clk);
      f_en = 1'b0; j_req = 1'b0;
      if (f_rdy) begin nrdy++; if (fk < 0) begin fk = cyc; fd = f_dout; end end
      if (pb && !busy && jk < 0) jk = cyc;
      if (sys_rst) begin nrst++; rk = cyc; end
      pb = busy;
    end
  endtask

  task automatic apply_f(input bit fw, input int fa, input logic [15:0] fdv, output logic [15:0] efd);
    efd = shadow[fa];
    if (fw) shadow[fa] = fdv;
    emod = 1'b0;
  endtask

  task automatic apply_j(input logic [3:0] jc, input int ja, input logic [15:0] jdv);
    if (jc == 4'h2) begin
      if (ja != 0 && ja != 2 && ja != 3) shadow[ja] = jdv;
      emod = 1'b1;
    end else ejd = shadow[ja];
  endtask

  task automatic op(input string req, input bit df, input bit fw, input int fa, input logic [15:0] fdv,
                    input int f_at, input bit dj, input logic [3:0] jc, input int ja,
                    input logic [15:0] jdv, input int j_at);
    bit jfirst;
    logic [15:0] efd;
    efd = '0;
    jfirst = dj && (!df || j_at <= f_at);
    if (jfirst) begin apply_j(jc, ja, jdv); if (df) apply_f(fw, fa, fdv, efd); end
    else begin if (df) apply_f(fw, fa, fdv, efd); if (dj) apply_j(jc, ja, jdv); end
    run(df, fw, fa, fdv, f_at, dj, jc, ja, jdv, j_at);
    if (df) begin
      chk(fk == fin_at(f_at, dj && jfirst), {req, " fabric ready cycle"}, fk, fin_at(f_at, dj && jfirst));
      chk(nrdy == 1, {req, " one ready pulse"}, nrdy, 1);
      if (!fw) chk(fd == efd, {req, " fabric read data"}, fd, efd);
    end
    if (dj) chk(jk == fin_at(j_at, df && !jfirst), {req, " busy fall cycle"}, jk, fin_at(j_at, df && !jfirst));
    chk(j_dout == ejd, {req, " R10 scan read data"}, j_dout, ejd);
    chk(modified == emod, {req, " R6 modified"}, modified, emod);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !f_rdy && !modified && !aux_en && !sys_rst, "R11 reset outputs low",
        {busy, f_rdy, modified, aux_en, sys_rst}, 0);
    chk(locked, "R11 locked in reset", locked, 1);
    rst_n = 1'b1;
    repeat (WARM - 1) @(posedge clk);
    @(negedge clk);
    chk(locked, "R11 locked during warm-up", locked, 1);
    @(posedge clk); @(negedge clk);
    chk(!locked, "R11 unlocked after warm-up", locked, 0);

    for (int a = 0; a < 64; a++)
      op("R1 preload", 1, 1, a, 16'($urandom), 0, 0, 4'h0, 0, 16'h0, 0);
    op("R1 fabric read", 1, 0, 10, 16'h0, 0, 0, 4'h0, 0, 16'h0, 0);

    // R2: second enable while first still outstanding
    begin
      int cnt_r;
      cnt_r = 0;
      f_en = 1; f_we = 1; f_addr = AW'(8); f_din = 16'h1234;
      @(posedge clk); @(negedge clk);
      f_din = 16'hbeef; f_addr = AW'(9);
      @(posedge clk); @(negedge clk);
      if (f_rdy) cnt_r++;
      f_en = 0;
      for (int i = 0; i < WIN; i++) begin @(posedge clk); @(negedge clk); if (f_rdy) cnt_r++; end
      chk(cnt_r == 1, "R2 ignored enable gives no extra ready", cnt_r, 1);
      shadow[8] = 16'h1234; emod = 1'b0;
      op("R2 first write kept", 1, 0, 8, 16'h0, 0, 0, 4'h0, 0, 16'h0, 0);
      op("R2 ignored write not stored", 1, 0, 9, 16'h0, 0, 0, 4'h0, 0, 16'h0, 0);
    end

    op("R3 fabric write then scan read", 1, 1, 20, 16'haaaa, 0, 1, 4'h1, 20, 16'h0, 1);
    op("R4 scan write then queued fabric read", 1, 0, 21, 16'h0, 1, 1, 4'h2, 21, 16'h5a5a, 0);
    op("R13 same-cycle requests", 1, 0, 22, 16'h0, 0, 1, 4'h2, 22, 16'hc3c3, 0);
    op("R6 scan write sets modified", 0, 0, 0, 16'h0, 0, 1, 4'h2, 23, 16'h7777, 0);
    op("R10 scan read", 0, 0, 0, 16'h0, 0, 1, 4'h1, 23, 16'h0, 0);
    op("R10 hold across write", 0, 0, 0, 16'h0, 0, 1, 4'h2, 24, 16'h1111, 0);

    // R12: non-command requests
    begin
      int bs;
      bs = 0;
      j_req = 1; j_cmd = 4'h0; j_addr = AW'(5); j_din = 16'hdead;
      @(posedge clk); @(negedge clk);
      j_cmd = 4'ha;
      @(posedge clk); @(negedge clk);
      j_req = 0;
      for (int i = 0; i < WIN; i++) begin @(posedge clk); @(negedge clk); if (busy) bs++; end
      chk(bs == 0, "R12 busy stays low", bs, 0);
      chk(j_dout == ejd, "R12 scan data unchanged", j_dout, ejd);
      chk(modified == emod, "R12 modified unchanged", modified, emod);
      op("R12 memory unchanged", 0, 0, 0, 16'h0, 0, 1, 4'h1, 5, 16'h0, 0);
    end

    op("R8 reset write", 0, 0, 0, 16'h0, 0, 1, 4'h2, 3, 16'h9999, 0);
    chk(rk == jk && nrst == 1, "R8 one reset pulse with busy fall", rk, jk);
    op("R8 word at 3 unchanged", 0, 0, 0, 16'h0, 0, 1, 4'h1, 3, 16'h0, 0);

    op("R9 other value", 0, 0, 0, 16'h0, 0, 1, 4'h2, 2, 16'h0005, 0);
    chk(!aux_en, "R9 aux stays low", aux_en, 0);
    op("R9 enable value", 0, 0, 0, 16'h0, 0, 1, 4'h2, 2, 16'h0001, 0);
    chk(aux_en, "R9 aux set", aux_en, 1);
    op("R9 word at 2 unchanged", 0, 0, 0, 16'h0, 0, 1, 4'h1, 2, 16'h0, 0);

    op("R7 lock", 0, 0, 0, 16'h0, 0, 1, 4'h2, 0, 16'h0001, 0);
    chk(locked, "R7 locked set", locked, 1);
    op("R7 other value", 0, 0, 0, 16'h0, 0, 1, 4'h2, 0, 16'h0002, 0);
    chk(locked, "R7 lock unchanged", locked, 1);
    run(1, 1, 7, 16'h4321, 0, 0, 4'h0, 0, 16'h0, 0);
    chk(nrdy == 0, "R7 no ready while locked", nrdy, 0);
    op("R7 pending write not done", 0, 0, 0, 16'h0, 0, 1, 4'h1, 7, 16'h0, 0);
    chk(nrdy == 0, "R7 still held", nrdy, 0);
    run(0, 0, 0, 16'h0, 0, 1, 4'h2, 0, 16'h0000, 0);
    chk(!locked, "R7 unlocked", locked, 0);
    chk(fk == 2 * LAT + 2, "R7 held request completes after unlock", fk, 2 * LAT + 2);
    shadow[7] = 16'h4321; emod = 1'b0;
    chk(modified == 1'b0, "R7 R6 modified cleared by fabric", modified, 0);
    op("R7 held write stored", 0, 0, 0, 16'h0, 0, 1, 4'h1, 7, 16'h0, 0);

    for (int it = 0; it < 200; it++) begin
      int sc, fa, ja;
      bit fw;
      logic [3:0] jc;
      sc = $urandom_range(0, 4);
      fa = $urandom_range(4, 63); ja = $urandom_range(4, 63);
      fw = 1'($urandom); jc = $urandom_range(0, 1) ? 4'h2 : 4'h1;
      case (sc)
        0: op("R1 random", 1, fw, fa, 16'($urandom), 0, 0, jc, ja, 16'h0, 0);
        1: op("R5 random", 0, fw, fa, 16'h0, 0, 1, jc, ja, 16'($urandom), 0);
        2: op("R3 random", 1, fw, fa, 16'($urandom), 0, 1, jc, ja, 16'($urandom), 1);
        3: op("R4 random", 1, fw, fa, 16'($urandom), 1, 1, jc, ja, 16'($urandom), 0);
        default: op("R13 random", 1, fw, fa, 16'($urandom), 0, 1, jc, ja, 16'($urandom), 0);
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule